// File: doc/BRIEF.md
# Bus Write Hit Counter Target

This block is a byte-wide slave that gives software a way to exercise bus writes and check them. It answers on two address windows, a memory window and an I/O window. Each window has its own write strobe, and both share one read port. A write of a small test number to offset 0 selects one of six test slots, which is then armed. There are three test kinds per window: counting without a notify flag, counting any data with a notify flag, and counting only a specific data byte with a notify flag. The slot index is `window*3 + kind`, where memory is window 0 and I/O is window 1.

While a slot is armed, each write that lands on that slot's trigger offset, and that passes the slot's data rule, adds one to a 32-bit hit counter. Software reads the counter back through a self-describing little-endian header of the armed slot, which ends in a short ASCII slot name. Slots of the two notify kinds raise a sticky per-slot notify output on each counted write. Reading the armed slot's header clears that flag.

Top module: `bus_probe_target`

## Requirements
- R1: After reset no slot is armed, `notify` is all zero, every read returns 0x00, and writes to nonzero offsets change nothing.
- R2: A write to offset 0 with value v < 3 first disarms, then arms slot v (memory strobe) or slot 3+v (I/O strobe). It clears the hit counter to 0 and clears the notify flag of that slot. Header byte 0 then reads the slot index.
- R3: A write to offset 0 with value 3 or more leaves the block disarmed, so reads return 0x00.
- R4: A write on either strobe is counted (+1) when a slot is armed and the address equals the slot's trigger offset, and, for kinds 0 and 2, `wr_bytes` is 1 and the data is 0xFA. Kind 1 counts any data and any size.
- R5: The trigger offset of slot i is MEM_WIN+i for i = 0..2 (2048..2050) and IO_WIN+i for i = 3..5 (131..133).
- R6: A write with a wrong address, a wrong data byte or a wrong size (kinds 0 and 2), or a write while disarmed, leaves the counter and notify unchanged.
- R7: The header bytes are as follows. Byte 0 is the slot index. Byte 1 is 1. Bytes 4..7 are the trigger offset, little-endian. Byte 8 is the match byte: 0xFA, or 0xCE for kind 1. Bytes 12..15 are the counter, little-endian. Bytes 2, 3 and 9..11 read 0.
- R8: From byte 16 the header holds the slot name: "mem-" or "io-" followed by "none", "any" or "match". A read at an offset equal to or past 16 plus the name length returns 0x00, and this includes the terminating NUL.
- R9: Read data is registered. It appears on `rd_data` in the cycle after the `rd_en` edge and holds until the next read.
- R10: A counted write to a slot of kind 1 or 2 sets that slot's `notify` bit, which stays set. Kind 0 never sets it. An in-range header read of the armed slot clears its bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_wr_en | input | 1 | Write strobe, memory window |
| io_wr_en | input | 1 | Write strobe, I/O window |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 8 | Write data byte |
| wr_bytes | input | 4 | Access size of the write in bytes |
| rd_en | input | 1 | Read strobe (either window) |
| rd_addr | input | ADDR_W | Read byte offset into the header |
| rd_data | output | 8 | Registered read data |
| notify | output | 6 | Sticky per-slot notify flags |

## Verification
The assertions assume that the two write strobes are never high in the same cycle, and that the slot register only ever holds one of the six legal indices. The bench raises one strobe at a time and drives every input on the falling clock edge, one access per cycle. The counter-step and notify-rise properties assume at most one write per cycle, and the stimulus keeps to that.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
    localparam int KINDS      = 3;
    localparam int WINDOWS    = 2;
    localparam int SLOTS      = KINDS * WINDOWS;
    localparam int SLOT_W     = $clog2(SLOTS);
    localparam int CNT_W      = 32;
    localparam int HDR_FIXED  = 16;
    localparam int NAME_W     = 4;
    localparam logic [7:0] MATCH_BYTE = 8'hFA;
    localparam logic [7:0] ANY_BYTE   = 8'hCE;

    typedef enum logic [1:0] {
        K_SILENT = 2'd0,
        K_ANY    = 2'd1,
        K_MATCH  = 2'd2
    } kind_e;

    typedef struct packed {
        logic              armed;
        logic [SLOT_W-1:0] slot;
        logic [CNT_W-1:0]  count;
        logic [SLOTS-1:0]  notify;
        logic [7:0]        rd_data;
    } state_t;

    function automatic kind_e slot_kind(input logic [SLOT_W-1:0] s);
        return (s < SLOT_W'(KINDS)) ? kind_e'(s[1:0]) : kind_e'(2'(s - SLOT_W'(KINDS)));
    endfunction

    function automatic logic [31:0] trig_off(input logic [SLOT_W-1:0] s,
                                             input int mem_win, input int io_win);
        return (s < SLOT_W'(KINDS)) ? 32'(mem_win) + 32'(s) : 32'(io_win) + 32'(s);
    endfunction
endpackage

// File: rtl/bpt_name_rom.sv
module bpt_name_rom
    import bpt_pkg::*;
(
    input  logic [SLOT_W-1:0] slot,
    input  logic [NAME_W-1:0] idx,
    output logic [7:0]        chr,
    output logic [NAME_W-1:0] len
);
    localparam logic [23:0] MEM_STR   = "mem";
    localparam logic [15:0] IO_STR    = "io";
    localparam logic [31:0] SILENT_STR = "none";
    localparam logic [23:0] ANY_STR   = "any";
    localparam logic [39:0] MATCH_STR = "match";

    always_comb begin
        int plen, klen, i, j;
        logic io;
        kind_e k;
        io   = (slot >= SLOT_W'(KINDS));
        k    = slot_kind(slot);
        plen = io ? 2 : 3;
        case (k)
            K_SILENT: klen = 4;
            K_ANY:    klen = 3;
            default:  klen = 5;
        endcase
        len = NAME_W'(plen + 1 + klen);
        i   = int'(idx);
        j   = i - plen - 1;
        chr = 8'h00;
        if (i < plen) begin
            chr = io ? IO_STR[8*(1-i) +: 8] : MEM_STR[8*(2-i) +: 8];
        end else if (i == plen) begin
            chr = 8'h2D;
        end else if (j < klen) begin
            case (k)
                K_SILENT: chr = SILENT_STR[8*(3-j) +: 8];
                K_ANY:    chr = ANY_STR[8*(2-j) +: 8];
                default:  chr = MATCH_STR[8*(4-j) +: 8];
            endcase
        end
    end
endmodule

// File: rtl/bpt_hdr_read.sv
module bpt_hdr_read
    import bpt_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int MEM_WIN = 2048,
    parameter int IO_WIN  = 128
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic [CNT_W-1:0]  count,
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        byte_o,
    output logic              in_range
);
    logic [7:0]        name_chr;
    logic [NAME_W-1:0] name_len;
    logic [31:0]       off;

    bpt_name_rom u_rom (
        .slot (slot),
        .idx  (NAME_W'(int'(addr) - HDR_FIXED)),
        .chr  (name_chr),
        .len  (name_len)
    );

    always_comb begin
        off      = trig_off(slot, MEM_WIN, IO_WIN);
        in_range = int'(addr) < HDR_FIXED + int'(name_len);
        byte_o   = 8'h00;
        if (int'(addr) >= HDR_FIXED) begin
            byte_o = name_chr;
        end else begin
            case (addr[3:0])
                4'd0:  byte_o = 8'(slot);
                4'd1:  byte_o = 8'd1;
                4'd4:  byte_o = off[7:0];
                4'd5:  byte_o = off[15:8];
                4'd6:  byte_o = off[23:16];
                4'd7:  byte_o = off[31:24];
                4'd8:  byte_o = (slot_kind(slot) == K_ANY) ? ANY_BYTE : MATCH_BYTE;
                4'd12: byte_o = count[7:0];
                4'd13: byte_o = count[15:8];
                4'd14: byte_o = count[23:16];
                4'd15: byte_o = count[31:24];
                default: byte_o = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/bus_probe_target.sv
module bus_probe_target
    import bpt_pkg::*;
#(
    parameter int MEM_WIN = 2048,
    parameter int IO_WIN  = 128,
    localparam int ADDR_W = $clog2(2 * MEM_WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_wr_en,
    input  logic              io_wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [3:0]        wr_bytes,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [SLOTS-1:0]  notify
);
    state_t st_d, st_q;
    logic [7:0] hdr_byte;
    logic       hdr_ok;
    logic       wr_any, arm_wr, hit;
    kind_e      cur_kind;

    bpt_hdr_read #(.ADDR_W(ADDR_W), .MEM_WIN(MEM_WIN), .IO_WIN(IO_WIN)) u_hdr (
        .slot     (st_q.slot),
        .count    (st_q.count),
        .addr     (rd_addr),
        .byte_o   (hdr_byte),
        .in_range (hdr_ok)
    );

    always_comb begin
        st_d     = st_q;
        cur_kind = slot_kind(st_q.slot);
        wr_any   = mem_wr_en | io_wr_en;
        arm_wr   = wr_any && (wr_addr == '0);
        hit      = wr_any && !arm_wr && st_q.armed
                   && (32'(wr_addr) == trig_off(st_q.slot, MEM_WIN, IO_WIN))
                   && ((cur_kind == K_ANY)
                       || ((wr_bytes == 4'd1) && (wr_data == MATCH_BYTE)));

        if (rd_en) begin
            st_d.rd_data = (st_q.armed && hdr_ok) ? hdr_byte : 8'h00;
            if (st_q.armed && hdr_ok && cur_kind != K_SILENT)
                st_d.notify[st_q.slot] = 1'b0;
        end

        if (arm_wr) begin
            st_d.armed = 1'b0;
            if (wr_data < 8'(KINDS)) begin
                st_d.armed = 1'b1;
                st_d.slot  = (mem_wr_en ? SLOT_W'(0) : SLOT_W'(KINDS)) + SLOT_W'(wr_data[1:0]);
                st_d.count = '0;
                st_d.notify[st_d.slot] = 1'b0;
            end
        end else if (hit) begin
            st_d.count = st_q.count + 1'b1;
            if (cur_kind != K_SILENT)
                st_d.notify[st_q.slot] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rd_data;
    assign notify  = st_q.notify;

    // R1
    slot_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.armed |-> (st_q.slot < SLOT_W'(SLOTS)));

    // R2
    arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_wr && wr_data < 8'(KINDS)) |=> (st_q.armed && st_q.count == '0));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && !arm_wr) |=> (st_q.count == $past(st_q.count)
                                     || st_q.count == $past(st_q.count) + 1'b1));

    // R10
    notify_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(st_q.notify & ~$past(st_q.notify))) |-> (st_q.count == $past(st_q.count) + 1'b1));

    // R1
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !st_q.armed) |=> (rd_data == 8'h00));
endmodule

// File: tb/bus_probe_target_tb.sv
`timescale 1ns/1ps
module bus_probe_target_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_wr_en = 1'b0, io_wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0] wr_addr = '0, rd_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  wr_bytes = 4'd1;
    logic [7:0]  rd_data;
    logic [5:0]  notify;
    int total = 0, fails = 0;

    always #2 clk = ~clk;

    bus_probe_target u_dut (
        .clk(clk), .rst_n(rst_n), .mem_wr_en(mem_wr_en), .io_wr_en(io_wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_bytes(wr_bytes),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .notify(notify)
    );

    // {slot[3], io[1], value[2], trigger[12], kind[2]}
    localparam logic [19:0] VEC [6] = '{
        {3'd0, 1'b0, 2'd0, 12'd2048, 2'd0},
        {3'd1, 1'b0, 2'd1, 12'd2049, 2'd1},
        {3'd2, 1'b0, 2'd2, 12'd2050, 2'd2},
        {3'd3, 1'b1, 2'd0, 12'd131,  2'd0},
        {3'd4, 1'b1, 2'd1, 12'd132,  2'd1},
        {3'd5, 1'b1, 2'd2, 12'd133,  2'd2}
    };
    string NAMES [6] = '{"mem-none", "mem-any", "mem-match", "io-none", "io-any", "io-match"};

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input bit io, input logic [11:0] a, input logic [7:0] d, input logic [3:0] n);
        @(negedge clk);
        mem_wr_en = !io; io_wr_en = io; wr_addr = a; wr_data = d; wr_bytes = n;
        @(negedge clk);
        mem_wr_en = 1'b0; io_wr_en = 1'b0; wr_bytes = 4'd1;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic rd32(input logic [11:0] base, output logic [31:0] v);
        logic [7:0] b;
        for (int k = 0; k < 4; k++) begin
            rd(base + 12'(k), b);
            v[8*k +: 8] = b;
        end
    endtask

    initial begin
        #400000;
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0] b;
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(notify == 6'd0, "R1 notify after reset", notify, 0);
        rd(12'd0, b);
        chk(b == 8'h00, "R1 read while idle", b, 0);

        for (int s = 0; s < 6; s++) begin
            logic io;
            logic [11:0] trig;
            int kind, exp;
            io = VEC[s][16]; trig = VEC[s][13:2]; kind = int'(VEC[s][1:0]); exp = 0;
            wr(io, 12'd0, 8'(VEC[s][15:14]), 4'd1);
            rd(12'd0, b);
            chk(b == 8'(s), "R2 armed slot index", b, s);
            rd32(12'd12, w);
            chk(w == 0, "R2 counter cleared", w, 0);
            wr(io, trig, 8'hFA, 4'd1); exp++;
            wr(io, trig, 8'hFA, 4'd1); exp++;
            wr(io, trig + 12'd1, 8'hFA, 4'd1);
            wr(io, trig, 8'h12, 4'd1); if (kind == 1) exp++;
            wr(io, trig, 8'hFA, 4'd2); if (kind == 1) exp++;
            chk(notify[s] == (kind != 0), "R10 notify set by kind", notify[s], kind != 0);
            rd32(12'd12, w);
            chk(w == 32'(exp), "R4 R6 hit count", w, exp);
            rd(12'd1, b);  chk(b == 8'd1, "R7 width byte", b, 1);
            chk(notify[s] == 1'b0, "R10 read clears notify", notify[s], 0);
            rd32(12'd4, w);
            chk(w == 32'(trig), "R5 trigger offset", w, trig);
            rd(12'd8, b);
            chk(b == ((kind == 1) ? 8'hCE : 8'hFA), "R7 match byte", b, (kind == 1) ? 8'hCE : 8'hFA);
            rd(12'd2, b);  chk(b == 8'h00, "R7 pad byte 2", b, 0);
            rd(12'd10, b); chk(b == 8'h00, "R7 pad byte 10", b, 0);
            for (int k = 0; k < NAMES[s].len(); k++) begin
                rd(12'(16 + k), b);
                chk(b == NAMES[s][k], "R8 name char", b, NAMES[s][k]);
            end
            rd(12'(16 + NAMES[s].len()), b);
            chk(b == 8'h00, "R8 terminator", b, 0);
            rd(12'(17 + NAMES[s].len()), b);
            chk(b == 8'h00, "R8 past end", b, 0);
        end

        // R9: one-cycle registered read
        wr(1'b1, 12'd0, 8'd1, 4'd1);
        rd(12'd0, b);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 12'd1;
        #1 chk(rd_data == 8'd4, "R9 data held before edge", rd_data, 4);
        @(negedge clk);
        rd_en = 1'b0;
        chk(rd_data == 8'd1, "R9 data after one edge", rd_data, 1);

        // R3 and R6: out-of-range test number disarms, later writes ignored
        wr(1'b0, 12'd0, 8'd2, 4'd1);
        wr(1'b0, 12'd0, 8'd3, 4'd1);
        rd(12'd0, b);
        chk(b == 8'h00, "R3 disarmed read", b, 0);
        rd(12'd1, b);
        chk(b == 8'h00, "R3 disarmed width read", b, 0);
        wr(1'b0, 12'd2050, 8'hFA, 4'd1);
        chk(notify == 6'd0, "R6 write while disarmed", notify, 0);

        // R1: reset while armed
        wr(1'b0, 12'd0, 8'd1, 4'd1);
        wr(1'b0, 12'd2049, 8'h55, 4'd1);
        chk(notify[1] == 1'b1, "R10 wildcard hit sets notify", notify[1], 1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk(notify == 6'd0, "R1 reset clears notify", notify, 0);
        wr(1'b0, 12'd2049, 8'h55, 4'd1);
        chk(notify == 6'd0, "R1 writes ignored after reset", notify, 0);
        rd(12'd0, b);
        chk(b == 8'h00, "R1 read after reset", b, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule